// File: doc/BRIEF.md
# Transceiver Heartbeat Checker

This block watches for the transceiver's signal-quality self-test after each frame the transmitter completes. Some transceivers confirm that they are healthy by pulsing the collision line for a short while after the end of a frame. The block turns that pulse into a required response. When checking is switched on and no pulse arrives within a fixed window of clocks after the end of the frame, the block closes the buffer descriptor with a heartbeat-error flag set. It can also raise a transmit-error interrupt, which a separate enable gates.

A collision that arrives inside the window counts as proof that the transceiver is alive. It is never reported as a collision error. If a new frame ends while a window is still open, the count starts again from the new frame. When checking is switched off, the counter stays idle. Switching checking off also abandons any window that is open at that moment.

Top module: `hb_monitor`

## Requirements
- R1: After reset, `buf_close_o`, `hb_err_o` and `irq_o` are all 0.
- R2: With checking enabled, the collision input may be sampled high on any of the WIN_LEN (default 20) rising edges that follow the edge that sampled `frame_done_i`. If it is, no buffer close and no heartbeat error are produced for that frame, and `hb_err_o` stays 0.
- R3: With checking enabled and no collision in those WIN_LEN edges, `buf_close_o` is 1 for exactly one cycle. That cycle starts at edge number WIN_LEN after the strobe edge. On the same edge `hb_err_o` becomes 1.
- R4: A collision sampled on the same edge as the end-of-frame strobe does not count as a heartbeat. Neither does a collision sampled on edge WIN_LEN+1 or later. Either case still gives the error of R3.
- R5: `irq_o` pulses together with `buf_close_o` only when `txe_irq_en_i` is 1 during the expiring cycle. Otherwise it stays 0.
- R6: While `check_en_i` is 0, end-of-frame strobes are ignored and any open window is abandoned. No close, no flag change and no interrupt result from either.
- R7: A strobe accepted while a window is open restarts the count. The earlier frame produces no report, and the error follows WIN_LEN edges after the latest strobe.
- R8: If a window expires on the same edge that accepts a new strobe, the expiring frame is still reported per R3. A fresh window also starts for the new frame.
- R9: `hb_err_o` holds its value until the next accepted end-of-frame strobe, which clears it. A set caused by an expiry on that same edge takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_done_i | input | 1 | One-cycle strobe: transmitter finished a frame |
| collision_i | input | 1 | Collision line from the transceiver |
| check_en_i | input | 1 | Heartbeat check enable |
| txe_irq_en_i | input | 1 | Transmit-error interrupt mask (1 = enabled) |
| hb_err_o | output | 1 | Heartbeat-error status flag for the closed buffer |
| buf_close_o | output | 1 | One-cycle strobe that closes the buffer on a heartbeat error |
| irq_o | output | 1 | Masked transmit-error interrupt pulse |

## Verification
Two events can fall on the same clock edge: the expiry of an open window and the acceptance of a new end-of-frame strobe. The bench provokes this by issuing the second strobe on exactly the WIN_LEN-th edge after the first. The scoreboard then expects two separate closes, WIN_LEN cycles apart. It also expects the error flag to read 1 at the first close, because the set takes precedence over the clear. The restart case is judged with the same scoreboard. There, a strobe arrives five edges into a window, and only one close is expected, timed from the later strobe.

// File: rtl/hb_pkg.sv
package hb_pkg;
    localparam int DEFAULT_WIN_LEN = 20;

    typedef struct packed {
        logic close;
        logic err;
        logic irq;
    } hb_report_t;
endpackage

// File: rtl/hb_window.sv
module hb_window #(
    parameter int WIN_LEN = hb_pkg::DEFAULT_WIN_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic start_i,
    input  logic coll_i,
    output logic expire_o
);
    localparam int CW = $clog2(WIN_LEN + 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } win_state_t;

    win_state_t win_d, win_q;

    always_comb begin
        win_d    = win_q;
        expire_o = en_i && win_q.active && (win_q.cnt == CW'(1)) && !coll_i;
        if (!en_i) begin
            win_d.active = 1'b0;
            win_d.cnt    = '0;
        end else if (start_i) begin
            win_d.active = 1'b1;
            win_d.cnt    = CW'(WIN_LEN);
        end else if (win_q.active) begin
            if (coll_i || (win_q.cnt == CW'(1))) begin
                win_d.active = 1'b0;
                win_d.cnt    = '0;
            end else begin
                win_d.cnt = win_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && start_i) |=> (win_q.active && win_q.cnt == CW'(WIN_LEN))); // R7
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        win_q.active |-> (win_q.cnt >= CW'(1) && win_q.cnt <= CW'(WIN_LEN))); // R3
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !win_q.active); // R6
endmodule

// File: rtl/hb_report.sv
module hb_report
    import hb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic start_i,
    input  logic irq_en_i,
    output logic close_o,
    output logic err_o,
    output logic irq_o
);
    hb_report_t rep_d, rep_q;

    always_comb begin
        rep_d       = rep_q;
        rep_d.close = expire_i;
        rep_d.irq   = expire_i && irq_en_i;
        if (expire_i) begin
            rep_d.err = 1'b1;
        end else if (start_i) begin
            rep_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rep_q <= '0;
        end else begin
            rep_q <= rep_d;
        end
    end

    assign close_o = rep_q.close;
    assign err_o   = rep_q.err;
    assign irq_o   = rep_q.irq;

    AST_SINGLE_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        close_o |=> !close_o); // R3
    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !expire_i) |=> !err_o); // R9
endmodule

// File: rtl/hb_monitor.sv
module hb_monitor #(
    parameter int WIN_LEN = hb_pkg::DEFAULT_WIN_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_done_i,
    input  logic collision_i,
    input  logic check_en_i,
    input  logic txe_irq_en_i,
    output logic hb_err_o,
    output logic buf_close_o,
    output logic irq_o
);
    logic start_s;
    logic expire_s;

    assign start_s = frame_done_i && check_en_i;

    hb_window #(.WIN_LEN(WIN_LEN)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (check_en_i),
        .start_i  (start_s),
        .coll_i   (collision_i),
        .expire_o (expire_s)
    );

    hb_report u_report (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire_i (expire_s),
        .start_i  (start_s),
        .irq_en_i (txe_irq_en_i),
        .close_o  (buf_close_o),
        .err_o    (hb_err_o),
        .irq_o    (irq_o)
    );

    AST_IRQ_WITH_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> buf_close_o); // R5
    AST_CLOSE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        buf_close_o |-> hb_err_o); // R3
    AST_NO_CLOSE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !check_en_i |=> !buf_close_o); // R6
    AST_HEARTBEAT_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (collision_i && !frame_done_i) |=> !buf_close_o); // R2
endmodule

// File: tb/hb_monitor_tb.sv
module hb_monitor_tb;
    localparam int WIN = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_done = 1'b0;
    logic collision = 1'b0;
    logic check_en = 1'b1;
    logic irq_en = 1'b1;
    logic hb_err, buf_close, irq;

    int cyc = 0;
    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        bit    irq;
        string req;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hb_monitor #(.WIN_LEN(WIN)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_done_i (frame_done),
        .collision_i  (collision),
        .check_en_i   (check_en),
        .txe_irq_en_i (irq_en),
        .hb_err_o     (hb_err),
        .buf_close_o  (buf_close),
        .irq_o        (irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic push(input int at, input bit ir, input string req);
        exp_t e;
        e.at = at; e.irq = ir; e.req = req;
        exp_q.push_back(e);
    endtask

    // monitor: pops expected closes as the design produces them
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_q.size() > 0 && exp_q[0].at < cyc) begin
                chk(exp_q[0].req, "missed close at cycle", 0, exp_q[0].at);
                void'(exp_q.pop_front());
            end
            if (buf_close) begin
                if (exp_q.size() == 0) begin
                    chk("R2", "unexpected close", 1, 0);
                end else begin
                    chk(exp_q[0].req, "close cycle", cyc, exp_q[0].at);
                    chk("R5", "irq with close", int'(irq), int'(exp_q[0].irq));
                    chk("R3", "flag at close", int'(hb_err), 1);
                    void'(exp_q.pop_front());
                end
            end else begin
                chk("R5", "irq without close", int'(irq), 0);
            end
        end
    end

    // driver: one frame, collision on relative edge coll_k (-1 = none)
    task automatic run_frame(input int coll_k, input bit expect_close, input string req);
        int n0;
        @(negedge clk);
        n0 = cyc + 1;
        frame_done = 1'b1;
        collision = (coll_k == 0);
        if (expect_close) push(n0 + WIN, irq_en, req);
        for (int k = 1; k <= 25; k++) begin
            @(negedge clk);
            frame_done = 1'b0;
            collision = (coll_k == k);
        end
        collision = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                if (!done) begin
                    n_checks++; n_errors++;
                    $display("FAIL watchdog: actual=timeout expected=finish");
                    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
                    $finish;
                end
            end
        join_none

        idle(3);
        chk("R1", "close after reset", int'(buf_close), 0);
        chk("R1", "flag after reset", int'(hb_err), 0);
        chk("R1", "irq after reset", int'(irq), 0);
        rst_n = 1'b1;
        idle(2);

        // R3 / R5: no heartbeat, interrupt enabled
        run_frame(-1, 1'b1, "R3");
        chk("R3", "flag held", int'(hb_err), 1);

        // R2 + R9: heartbeat on first edge; flag cleared by the strobe
        run_frame(1, 1'b0, "R2");
        chk("R9", "flag cleared", int'(hb_err), 0);

        // R2: heartbeat on last edge of window
        run_frame(WIN, 1'b0, "R2");
        chk("R2", "flag after late-window heartbeat", int'(hb_err), 0);

        // R4: collision on strobe edge only; interrupt masked (R5)
        irq_en = 1'b0;
        run_frame(0, 1'b1, "R4");
        irq_en = 1'b1;

        // R4: collision one edge too late
        run_frame(WIN + 1, 1'b1, "R4");
        chk("R9", "flag held until next strobe", int'(hb_err), 1);

        // R6: strobe ignored while disabled; flag untouched
        check_en = 1'b0;
        run_frame(-1, 1'b0, "R6");
        chk("R6", "flag unchanged while disabled", int'(hb_err), 1);
        check_en = 1'b1;

        // R6: window abandoned when enable drops mid-window
        @(negedge clk);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        idle(9);
        check_en = 1'b0;
        @(negedge clk);
        check_en = 1'b1;
        idle(30);
        chk("R6", "flag after abandoned window", int'(hb_err), 0);

        // R7: restart five edges into a window
        begin
            int n1;
            @(negedge clk);
            frame_done = 1'b1;
            @(negedge clk);
            frame_done = 1'b0;
            idle(3);
            @(negedge clk);
            n1 = cyc + 1;
            frame_done = 1'b1;
            push(n1 + WIN, 1'b1, "R7");
            @(negedge clk);
            frame_done = 1'b0;
            idle(30);
        end

        // R8: new strobe on the expiring edge
        begin
            int n0, n1;
            @(negedge clk);
            n0 = cyc + 1;
            frame_done = 1'b1;
            push(n0 + WIN, 1'b1, "R8");
            @(negedge clk);
            frame_done = 1'b0;
            idle(WIN - 2);
            @(negedge clk);
            n1 = cyc + 1;
            chk("R8", "second strobe on expiry edge", n1, n0 + WIN);
            frame_done = 1'b1;
            push(n1 + WIN, 1'b1, "R8");
            @(negedge clk);
            frame_done = 1'b0;
            chk("R9", "set wins over clear", int'(hb_err), 1);
            idle(30);
        end

        chk("R3", "pending expected closes", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule